// File: doc/BRIEF.md
# Branch Direction Predictor and Redirect Unit

This block predicts conditional branches for a short in-order pipeline whose fetch stage runs a pointer two instruction slots ahead of the current program counter. A direct-mapped table, indexed by bits of the branch address, holds for each entry a valid flag, a 2-bit saturating direction counter and the last taken target. When fetch reports a branch, the block returns the predicted direction and the value to load into the two-ahead fetch pointer.

When the branch resolves later in the pipeline, the resolve port carries the branch address, the real outcome, the computed target, the fall-through address and the direction that was predicted for it. The block updates the table entry. In the same cycle it tells the pipeline how many younger slots to squash (none, one or two) and whether the fetch pointer must be redirected, and to which address. The table write is visible to a lookup of the same index in the same cycle, so a branch that is fetched again while its previous instance resolves sees the updated counter.

Top module: `bp_redirect_unit`

## Requirements
- R1: After reset every entry is invalid: a lookup misses (`lk_hit` = 0) and, with `rs_valid` low, `fl_depth` = 0 and `rd_valid` = 0.
- R2: The table index is PC[9:2] with no tag, so two branch addresses with equal bits 9..2 (for example 0x100 and 0x500) share one entry.
- R3: A lookup that misses predicts taken (`lk_pred_taken` = 1) and drives `lk_next2_pc` with `lk_dec_target`.
- R4: A lookup that hits predicts the counter's upper bit (1 = taken); `lk_next2_pc` is the stored target when taken and `lk_pc` + 8 when not taken.
- R5: Resolving a branch whose entry is invalid allocates it with counter 2'b10 (weakly taken) and the resolved target, whatever the outcome.
- R6: On a valid entry the counter (2'b00 strongly not taken .. 2'b11 strongly taken) increments on taken and decrements on not taken, holding at 2'b11 and 2'b00; back-to-back resolves each apply.
- R7: Predicted taken and taken: `fl_depth` = 1, `rd_valid` = 0.
- R8: Predicted taken but not taken: `fl_depth` = 2, `rd_valid` = 1, `rd_pc` = `rs_fall_pc`.
- R9: Predicted not taken and not taken: `fl_depth` = 0, `rd_valid` = 0.
- R10: Predicted not taken but taken: `fl_depth` = 1, `rd_valid` = 1, `rd_pc` = `rs_target`.
- R11: A lookup in the same cycle as a resolve of the same index sees the entry as updated by that resolve.
- R12: With `rs_valid` low, `fl_depth` = 0, `rd_valid` = 0, `rd_pc` = 0 and the table is unchanged.
- R13: A taken resolve on a valid entry replaces the stored target; a not-taken resolve keeps it.
- R14: With `lk_valid` low, `lk_pred_taken` = 0, `lk_hit` = 0 and `lk_next2_pc` = `lk_pc` + 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Fetched instruction is a conditional branch |
| lk_pc | input | 32 | Address of the fetched instruction |
| lk_dec_target | input | 32 | Target decoded from the branch immediate, used on a miss |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_pred_taken | output | 1 | Predicted direction, 1 = taken |
| lk_next2_pc | output | 32 | Value for the two-ahead fetch pointer |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | 32 | Address of the resolving branch |
| rs_taken | input | 1 | Real outcome, 1 = taken |
| rs_pred_taken | input | 1 | Direction that was predicted for this branch |
| rs_target | input | 32 | Computed branch target |
| rs_fall_pc | input | 32 | Sequential address after the branch |
| fl_depth | output | 2 | Younger slots to squash: 0, 1 or 2 |
| rd_valid | output | 1 | Redirect the two-ahead fetch pointer |
| rd_pc | output | 32 | Redirect address, 0 when `rd_valid` is low |

## Verification
The main pattern is one branch address driven through a run of outcomes chosen to walk its counter up into the strong-taken end and down past the strong-not-taken end, so that a wrapping counter, a missing allocation state or a missing same-cycle bypass each show up as a wrong predicted direction on the next lookup. All four pairings of predicted and real direction appear, which separates the flush depths and redirect sources from one another. A second address that aliases the first tells index-only addressing apart from tagged lookup, and a third address checks that allocation on a not-taken outcome still starts weakly taken and that target refresh happens only on taken outcomes. Idle resolve cycles carrying stray field values confirm that nothing is written or flushed without the valid strobe.

// File: rtl/bp_pkg.sv
// Shared types for the branch predictor: counter states and flush depths.
package bp_pkg;
    // 2-bit direction counter; upper bit is the predicted direction
    typedef enum logic [1:0] {
        CNT_STRONG_NT = 2'b00,
        CNT_WEAK_NT   = 2'b01,
        CNT_WEAK_T    = 2'b10,
        CNT_STRONG_T  = 2'b11
    } bp_cnt_e;

    // Number of younger pipeline slots to squash on resolution
    typedef enum logic [1:0] {
        FLUSH_NONE = 2'd0,
        FLUSH_ONE  = 2'd1,
        FLUSH_TWO  = 2'd2
    } bp_flush_e;
endpackage

// File: rtl/bp_entry_store.sv
// Direct-mapped prediction table: valid flag, counter and target per entry.
// Assumes one write per cycle. Read port 0 (lookup) forwards a same-cycle
// write to the same index when FWD_PORT0 is set; port 1 (resolve) is raw.
module bp_entry_store #(
    parameter int ENTRIES   = 256,
    parameter int XLEN      = 32,
    parameter bit FWD_PORT0 = 1'b1,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     rd_idx   [2],
    output logic                 rd_valid [2],
    output bp_pkg::bp_cnt_e      rd_state [2],
    output logic [XLEN-1:0]      rd_target[2],
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  bp_pkg::bp_cnt_e      wr_state,
    input  logic [XLEN-1:0]      wr_target
);
    logic [ENTRIES-1:0] valid_q;
    bp_pkg::bp_cnt_e    state_q  [ENTRIES];
    logic [XLEN-1:0]    target_q [ENTRIES];

    // Valid flags: cleared by reset, set on every write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Counter and target payload; contents are meaningless until valid
    always_ff @(posedge clk) begin
        if (wr_en) begin
            state_q[wr_idx]  <= wr_state;
            target_q[wr_idx] <= wr_target;
        end
    end

    // Read ports; port 0 may forward the write in flight
    for (genvar p = 0; p < 2; p++) begin : g_rd
        if (p == 0 && FWD_PORT0) begin : g_fwd
            logic same;
            assign same = wr_en && (wr_idx == rd_idx[p]);
            // Forwarded read: write data wins on an index match
            always_comb begin
                if (same) begin
                    rd_valid[p]  = 1'b1;
                    rd_state[p]  = wr_state;
                    rd_target[p] = wr_target;
                end else begin
                    rd_valid[p]  = valid_q[rd_idx[p]];
                    rd_state[p]  = state_q[rd_idx[p]];
                    rd_target[p] = target_q[rd_idx[p]];
                end
            end
        end else begin : g_raw
            // Plain registered read
            always_comb begin
                rd_valid[p]  = valid_q[rd_idx[p]];
                rd_state[p]  = state_q[rd_idx[p]];
                rd_target[p] = target_q[rd_idx[p]];
            end
        end
    end
endmodule

// File: rtl/bp_counter_next.sv
// Next direction counter for a resolving branch. Assumes the caller gates
// the result with the resolve strobe. A missing entry starts weakly taken.
module bp_counter_next (
    input  logic             cur_valid,
    input  bp_pkg::bp_cnt_e  cur_state,
    input  logic             taken,
    output bp_pkg::bp_cnt_e  nxt_state
);
    import bp_pkg::*;

    // Allocation or saturating step
    always_comb begin
        if (!cur_valid) begin
            nxt_state = CNT_WEAK_T;
        end else if (taken) begin
            nxt_state = (cur_state == CNT_STRONG_T) ? CNT_STRONG_T
                                                    : bp_cnt_e'(cur_state + 2'd1);
        end else begin
            nxt_state = (cur_state == CNT_STRONG_NT) ? CNT_STRONG_NT
                                                     : bp_cnt_e'(cur_state - 2'd1);
        end
    end
endmodule

// File: rtl/bp_outcome_ctrl.sv
// Flush depth and fetch redirect from predicted versus real direction.
// Assumes the predicted direction travels with the branch down the pipe.
module bp_outcome_ctrl #(
    parameter int XLEN = 32
) (
    input  logic              rs_valid,
    input  logic              pred_taken,
    input  logic              taken,
    input  logic [XLEN-1:0]   target,
    input  logic [XLEN-1:0]   fall_pc,
    output bp_pkg::bp_flush_e depth,
    output logic              redir,
    output logic [XLEN-1:0]   redir_pc
);
    import bp_pkg::*;

    // Four-way decode of the prediction outcome
    always_comb begin
        depth    = FLUSH_NONE;
        redir    = 1'b0;
        redir_pc = '0;
        if (rs_valid) begin
            unique case ({pred_taken, taken})
                2'b11: depth = FLUSH_ONE;
                2'b10: begin
                    depth    = FLUSH_TWO;
                    redir    = 1'b1;
                    redir_pc = fall_pc;
                end
                2'b01: begin
                    depth    = FLUSH_ONE;
                    redir    = 1'b1;
                    redir_pc = target;
                end
                default: depth = FLUSH_NONE;
            endcase
        end
    end
endmodule

// File: rtl/bp_redirect_unit.sv
// Top of the branch predictor. Lookup side returns direction and the
// two-ahead fetch pointer; resolve side updates the table and drives
// flush depth and redirect in the same cycle. Assumes at most one lookup
// and one resolve per cycle and 4-byte instructions.
module bp_redirect_unit #(
    parameter int ENTRIES    = 256,
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [XLEN-1:0] lk_pc,
    input  logic [XLEN-1:0] lk_dec_target,
    output logic            lk_hit,
    output logic            lk_pred_taken,
    output logic [XLEN-1:0] lk_next2_pc,
    input  logic            rs_valid,
    input  logic [XLEN-1:0] rs_pc,
    input  logic            rs_taken,
    input  logic            rs_pred_taken,
    input  logic [XLEN-1:0] rs_target,
    input  logic [XLEN-1:0] rs_fall_pc,
    output logic [1:0]      fl_depth,
    output logic            rd_valid,
    output logic [XLEN-1:0] rd_pc
);
    import bp_pkg::*;

    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int IDX_LO = $clog2(INSN_BYTES);
    localparam int IDX_HI = IDX_LO + IDX_W;
    localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * INSN_BYTES);

    logic [IDX_W-1:0] rd_idx   [2];
    logic             rd_vld   [2];
    bp_cnt_e          rd_state [2];
    logic [XLEN-1:0]  rd_tgt   [2];
    bp_cnt_e          wr_state;
    logic [XLEN-1:0]  wr_target;
    bp_flush_e        depth;
    logic             unused_pc_bits;

    // Index extraction for both ports
    assign rd_idx[0] = lk_pc[IDX_LO +: IDX_W];
    assign rd_idx[1] = rs_pc[IDX_LO +: IDX_W];
    assign unused_pc_bits = ^{rs_pc[XLEN-1:IDX_HI], rs_pc[IDX_LO-1:0]};

    bp_entry_store #(
        .ENTRIES  (ENTRIES),
        .XLEN     (XLEN),
        .FWD_PORT0(1'b1)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_valid (rd_vld),
        .rd_state (rd_state),
        .rd_target(rd_tgt),
        .wr_en    (rs_valid),
        .wr_idx   (rd_idx[1]),
        .wr_state (wr_state),
        .wr_target(wr_target)
    );

    bp_counter_next i_cnt (
        .cur_valid(rd_vld[1]),
        .cur_state(rd_state[1]),
        .taken    (rs_taken),
        .nxt_state(wr_state)
    );

    // Target refresh: allocation or taken outcome loads the resolved target
    always_comb begin
        wr_target = (rs_taken || !rd_vld[1]) ? rs_target : rd_tgt[1];
    end

    // Lookup: miss predicts taken toward the decoded target
    always_comb begin
        lk_hit        = lk_valid && rd_vld[0];
        lk_pred_taken = lk_valid && (!rd_vld[0] || rd_state[0][1]);
        if (lk_pred_taken) begin
            lk_next2_pc = rd_vld[0] ? rd_tgt[0] : lk_dec_target;
        end else begin
            lk_next2_pc = lk_pc + STEP2;
        end
    end

    bp_outcome_ctrl #(
        .XLEN(XLEN)
    ) i_outcome (
        .rs_valid  (rs_valid),
        .pred_taken(rs_pred_taken),
        .taken     (rs_taken),
        .target    (rs_target),
        .fall_pc   (rs_fall_pc),
        .depth     (depth),
        .redir     (rd_valid),
        .redir_pc  (rd_pc)
    );

    assign fl_depth = depth;
endmodule

// File: rtl/bp_redirect_checker.sv
// Port-level properties of the branch predictor, bound to the top.
module bp_redirect_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [XLEN-1:0] lk_pc,
    input logic [XLEN-1:0] lk_dec_target,
    input logic            lk_hit,
    input logic            lk_pred_taken,
    input logic [XLEN-1:0] lk_next2_pc,
    input logic            rs_valid,
    input logic            rs_taken,
    input logic            rs_pred_taken,
    input logic [XLEN-1:0] rs_target,
    input logic [XLEN-1:0] rs_fall_pc,
    input logic [1:0]      fl_depth,
    input logic            rd_valid,
    input logic [XLEN-1:0] rd_pc
);
    a_r3_miss_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit) |-> (lk_pred_taken && lk_next2_pc == lk_dec_target));

    a_r4_nt_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_pred_taken) |-> (lk_next2_pc == lk_pc + XLEN'(8)));

    a_r7_tt_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_pred_taken && rs_taken) |-> (fl_depth == 2'd1 && !rd_valid));

    a_r8_tn_two: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_pred_taken && !rs_taken)
        |-> (fl_depth == 2'd2 && rd_valid && rd_pc == rs_fall_pc));

    a_r9_nn_none: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_pred_taken && !rs_taken) |-> (fl_depth == 2'd0 && !rd_valid));

    a_r10_nt_target: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_pred_taken && rs_taken)
        |-> (fl_depth == 2'd1 && rd_valid && rd_pc == rs_target));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> (fl_depth == 2'd0 && !rd_valid && rd_pc == '0));

    a_r14_no_branch: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_pred_taken));
endmodule

bind bp_redirect_unit bp_redirect_checker #(.XLEN(XLEN)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_pc        (lk_pc),
    .lk_dec_target(lk_dec_target),
    .lk_hit       (lk_hit),
    .lk_pred_taken(lk_pred_taken),
    .lk_next2_pc  (lk_next2_pc),
    .rs_valid     (rs_valid),
    .rs_taken     (rs_taken),
    .rs_pred_taken(rs_pred_taken),
    .rs_target    (rs_target),
    .rs_fall_pc   (rs_fall_pc),
    .fl_depth     (fl_depth),
    .rd_valid     (rd_valid),
    .rd_pc        (rd_pc)
);

// File: tb/test_bp_redirect_unit.sv
`timescale 1ns/1ps
// Vector-driven bench for the branch predictor, then reset corner tests.
module test_bp_redirect_unit;
    localparam int XLEN = 32;
    localparam int NV   = 19;

    typedef struct packed {
        logic            lkv;
        logic [XLEN-1:0] lkpc;
        logic [XLEN-1:0] lktgt;
        logic            rsv;
        logic [XLEN-1:0] rspc;
        logic            rstk;
        logic            rspred;
        logic [XLEN-1:0] rstgt;
        logic [XLEN-1:0] rsfall;
        logic            e_pred;
        logic            e_hit;
        logic [XLEN-1:0] e_next2;
        logic [1:0]      e_depth;
        logic            e_rdv;
        logic [XLEN-1:0] e_rdpc;
    } vec_t;

    // A = 0x100, B = 0x104, C = 0x500 (aliases A)
    localparam vec_t VECS [NV] = '{
        '{1, 32'h100, 32'h200, 0, 32'h0,   0, 0, 32'h0,   32'h0,   1, 0, 32'h200, 2'd0, 0, 32'h0},
        '{1, 32'h100, 32'h300, 1, 32'h100, 1, 1, 32'h200, 32'h104, 1, 1, 32'h200, 2'd1, 0, 32'h0},
        '{1, 32'h100, 32'h300, 1, 32'h100, 0, 1, 32'h200, 32'h104, 0, 1, 32'h108, 2'd2, 1, 32'h104},
        '{1, 32'h100, 32'h300, 0, 32'h0,   0, 0, 32'h0,   32'h0,   0, 1, 32'h108, 2'd0, 0, 32'h0},
        '{1, 32'h104, 32'h180, 1, 32'h100, 1, 0, 32'h200, 32'h104, 1, 0, 32'h180, 2'd1, 1, 32'h200},
        '{1, 32'h100, 32'h300, 1, 32'h100, 1, 1, 32'h200, 32'h104, 1, 1, 32'h200, 2'd1, 0, 32'h0},
        '{1, 32'h100, 32'h300, 1, 32'h100, 1, 1, 32'h200, 32'h104, 1, 1, 32'h200, 2'd1, 0, 32'h0},
        '{1, 32'h100, 32'h300, 1, 32'h100, 0, 1, 32'h200, 32'h104, 1, 1, 32'h200, 2'd2, 1, 32'h104},
        '{1, 32'h100, 32'h300, 1, 32'h100, 0, 1, 32'h200, 32'h104, 0, 1, 32'h108, 2'd2, 1, 32'h104},
        '{0, 32'h300, 32'h0,   1, 32'h100, 0, 0, 32'h200, 32'h104, 0, 0, 32'h308, 2'd0, 0, 32'h0},
        '{1, 32'h100, 32'h300, 1, 32'h100, 0, 0, 32'h200, 32'h104, 0, 1, 32'h108, 2'd0, 0, 32'h0},
        '{1, 32'h100, 32'h300, 1, 32'h100, 1, 0, 32'h200, 32'h104, 0, 1, 32'h108, 2'd1, 1, 32'h200},
        '{1, 32'h500, 32'h600, 0, 32'h100, 1, 0, 32'h240, 32'h104, 0, 1, 32'h508, 2'd0, 0, 32'h0},
        '{1, 32'h100, 32'h300, 0, 32'h0,   0, 0, 32'h0,   32'h0,   0, 1, 32'h108, 2'd0, 0, 32'h0},
        '{1, 32'h104, 32'h190, 1, 32'h104, 0, 1, 32'h180, 32'h108, 1, 1, 32'h180, 2'd2, 1, 32'h108},
        '{1, 32'h104, 32'h190, 0, 32'h0,   0, 0, 32'h0,   32'h0,   1, 1, 32'h180, 2'd0, 0, 32'h0},
        '{0, 32'h0,   32'h0,   1, 32'h104, 1, 1, 32'h1C0, 32'h108, 0, 0, 32'h8,   2'd1, 0, 32'h0},
        '{1, 32'h104, 32'h190, 0, 32'h0,   0, 0, 32'h0,   32'h0,   1, 1, 32'h1C0, 2'd0, 0, 32'h0},
        '{1, 32'h104, 32'h190, 1, 32'h104, 0, 1, 32'h3C0, 32'h108, 1, 1, 32'h1C0, 2'd2, 1, 32'h108}
    };

    localparam string TAGS [NV] = '{
        "R3", "R5 R7 R11", "R8 R6 R11", "R4", "R10 R3", "R6", "R6", "R6 R8", "R6 R8",
        "R9 R14", "R6 R9", "R10 R6", "R2 R12", "R12", "R5 R8", "R5", "R13 R7 R14",
        "R13", "R13 R8"
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            lk_valid = 1'b0;
    logic [XLEN-1:0] lk_pc = '0;
    logic [XLEN-1:0] lk_dec_target = '0;
    logic            lk_hit;
    logic            lk_pred_taken;
    logic [XLEN-1:0] lk_next2_pc;
    logic            rs_valid = 1'b0;
    logic [XLEN-1:0] rs_pc = '0;
    logic            rs_taken = 1'b0;
    logic            rs_pred_taken = 1'b0;
    logic [XLEN-1:0] rs_target = '0;
    logic [XLEN-1:0] rs_fall_pc = '0;
    logic [1:0]      fl_depth;
    logic            rd_valid;
    logic [XLEN-1:0] rd_pc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bp_redirect_unit i_bp_redirect_unit (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_dec_target(lk_dec_target),
        .lk_hit(lk_hit), .lk_pred_taken(lk_pred_taken), .lk_next2_pc(lk_next2_pc),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
        .rs_pred_taken(rs_pred_taken), .rs_target(rs_target), .rs_fall_pc(rs_fall_pc),
        .fl_depth(fl_depth), .rd_valid(rd_valid), .rd_pc(rd_pc)
    );

    task automatic check(input string tag, input string what,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input vec_t v);
        check(tag, "lk_pred_taken", XLEN'(lk_pred_taken), XLEN'(v.e_pred));
        check(tag, "lk_hit",        XLEN'(lk_hit),        XLEN'(v.e_hit));
        check(tag, "lk_next2_pc",   lk_next2_pc,          v.e_next2);
        check(tag, "fl_depth",      XLEN'(fl_depth),      XLEN'(v.e_depth));
        check(tag, "rd_valid",      XLEN'(rd_valid),      XLEN'(v.e_rdv));
        check(tag, "rd_pc",         rd_pc,                v.e_rdpc);
    endtask

    task automatic drive(input vec_t v);
        lk_valid = v.lkv;  lk_pc = v.lkpc;  lk_dec_target = v.lktgt;
        rs_valid = v.rsv;  rs_pc = v.rspc;  rs_taken = v.rstk;
        rs_pred_taken = v.rspred;  rs_target = v.rstgt;  rs_fall_pc = v.rsfall;
    endtask

    // Reset sequence, then probe a lookup on an empty table
    task automatic reset_and_probe(input string tag);
        vec_t v;
        @(negedge clk);
        rst_n = 1'b0;
        v = '{0, 32'h0, 32'h0, 0, 32'h0, 0, 0, 32'h0, 32'h0,
              0, 0, 32'h0, 2'd0, 0, 32'h0};
        drive(v);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: after reset A misses and is predicted taken toward the decoded target
        v = '{1, 32'h100, 32'h2A0, 0, 32'h0, 0, 0, 32'h0, 32'h0,
              1, 0, 32'h2A0, 2'd0, 0, 32'h0};
        drive(v);
        #1;
        check_all(tag, v);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        reset_and_probe("R1 initial");
        // Vector walk: drive at negedge, sample 1 ns later, edge applies update
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            #1;
            check_all(TAGS[i], VECS[i]);
        end
        // R1: reset in the middle of use clears every learned entry
        reset_and_probe("R1 midrun");
        // R1: B was learned before the reset and must miss now
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = 32'h104; lk_dec_target = 32'h190;
        #1;
        check("R1", "lk_hit after reset", XLEN'(lk_hit), 32'h0);
        check("R1", "lk_next2_pc after reset", lk_next2_pc, 32'h190);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule